// File: doc/BRIEF.md
# Block-Protect Write Gate and Status Register

This unit sits beside the serial command decoder of a small serial nonvolatile memory. It holds the two block-protect bits and the write-enable latch, and it decides whether each write may go ahead. The decoder sends it one-cycle strobes for selection start and end, for every serial bit latched, and for the enable, disable, status-write and array-write commands. The write timer sends it a busy level. The unit returns the status byte for a status read, and one grant or deny pulse for every write request.

An array write comes with the first and last byte addresses of the page burst. The burst may wrap inside its page, so the last address can be lower than the first. The protected region always ends at the top of the array. The burst therefore touches it exactly when either end address is at or above the region's start.

Top module: `wprot_status_unit`

## Requirements
- R1: After reset `status_o` reads 0x00, the latch is clear, the protect level is 00, and `grant_o` and `deny_o` are low.
- R2: When `busy_i` is low, `status_o` is {4'b0000, level[1:0], latch, 1'b0}: the level in bits 3:2 and the latch in bit 1. When `busy_i` is high, `status_o` reads 0xFF.
- R3: An enable command sets the latch on the clock after `sel_end_i` only if no `bit_i` pulse arrives between `wren_i` and `sel_end_i`. One extra bit discards the command.
- R4: `wrdi_i` clears the latch. The latch also clears on the clock after `busy_i` falls. Enable and disable commands issued while `busy_i` is high have no effect.
- R5: A granted status write loads level[1:0] from `wrsr_data_i[3:2]`. All other data bits are ignored. A denied status write leaves the level unchanged.
- R6: Protection covers no addresses at level 00, addresses 0x180 and up at level 01, 0x100 and up at level 10, and the whole array at level 11. A burst is denied when `commit_lo_i` or `commit_hi_i` is in the protected region.
- R7: A write request is denied when `wp_i` is low in its request cycle.
- R8: A write request is denied when `wp_i` fell at any time during the current selection, even if `wp_i` has since returned high. A new selection clears this condition.
- R9: A write request is denied when the latch is clear, when `busy_i` is high, or when it arrives in the cycle right after a grant.
- R10: Each request (`commit_i` or `wrsr_i`) produces exactly one pulse, on `grant_o` or on `deny_o`, in the cycle after the request. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_start_i | input | 1 | Strobe: the device became selected |
| sel_end_i | input | 1 | Strobe: the selection ended |
| bit_i | input | 1 | Strobe: one serial bit was latched |
| wren_i | input | 1 | Strobe: an enable opcode completed |
| wrdi_i | input | 1 | Strobe: a disable opcode completed |
| wrsr_i | input | 1 | Strobe: request a status write |
| wrsr_data_i | input | 8 | Status write data byte |
| commit_i | input | 1 | Strobe: request an array burst write |
| commit_lo_i | input | ADDR_W | First byte address of the burst |
| commit_hi_i | input | ADDR_W | Last byte address of the burst |
| wp_i | input | 1 | Write-protect level, low blocks writes |
| busy_i | input | 1 | Write timer busy |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted, one cycle after it |
| deny_o | output | 1 | Request refused, one cycle after it |

## Verification
A latch stuck set or stuck clear shows on status bit 1 within one clock of the command that should have changed it. It also shows on the very next write request as the wrong verdict. A corrupted protect level shows in status bits 3:2 straight after the status write. It also shows when a burst at the region's edge (0x17F against 0x180, 0x0FF against 0x100) gets the wrong verdict. A lost cancel flag or a missing busy block lets a request through that should be refused, and this shows one cycle after the request.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } prot_lvl_e;

  localparam int unsigned STATUS_W = 8;
  localparam int unsigned LVL_LSB  = 2;
endpackage

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_start_i,
  input  logic sel_end_i,
  input  logic bit_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic busy_i,
  output logic wel_o
);
  logic armed_q, busy_q, wel_q;
  logic busy_fall;

  assign busy_fall = busy_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (sel_start_i)             armed_q <= 1'b0;
      else if (wren_i && !busy_i)  armed_q <= 1'b1;
      else if (bit_i || sel_end_i) armed_q <= 1'b0;
    end
  end

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 wel_q <= 1'b0;
    else if (wrdi_i && !busy_i)                  wel_q <= 1'b0;
    else if (busy_fall)                          wel_q <= 1'b0;
    else if (sel_end_i && armed_q && !busy_i)    wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  p_wel_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(sel_end_i && armed_q));
  p_wel_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_q) |-> $past(wrdi_i || (busy_q && !busy_i)));
endmodule

// File: rtl/wprot_bp.sv
module wprot_bp
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_lvl_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [1:0]        lvl_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] QTR_START  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_START = ADDR_W'(1) << (ADDR_W - 1);

  prot_lvl_e lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= LVL_NONE;
    else if (wr_en_i) lvl_q <= prot_lvl_e'(wr_lvl_i);
  end

  // region is top-aligned: a wrapped burst still hits iff an end is inside
  always_comb begin
    unique case (lvl_q)
      LVL_NONE: hit_o = 1'b0;
      LVL_QTR:  hit_o = (lo_i >= QTR_START) || (hi_i >= QTR_START);
      LVL_HALF: hit_o = (lo_i >= HALF_START) || (hi_i >= HALF_START);
      default:  hit_o = 1'b1;
    endcase
  end

  assign lvl_o = lvl_q;

  p_lvl_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(wr_en_i));
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_start_i,
  input  logic sel_end_i,
  input  logic commit_i,
  input  logic wrsr_i,
  input  logic wel_i,
  input  logic wp_i,
  input  logic busy_i,
  input  logic hit_i,
  output logic sr_wr_o,
  output logic grant_o,
  output logic deny_o
);
  logic sel_q, wp_q, dropped_q, grant_q, deny_q;
  logic req, ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      wp_q      <= 1'b1;
      dropped_q <= 1'b0;
    end else begin
      wp_q <= wp_i;
      if (sel_start_i)    sel_q <= 1'b1;
      else if (sel_end_i) sel_q <= 1'b0;
      if (sel_start_i)                     dropped_q <= 1'b0;
      else if (sel_q && wp_q && !wp_i)     dropped_q <= 1'b1;
    end
  end

  assign req = commit_i || wrsr_i;
  assign ok  = wel_i && wp_i && !dropped_q && !busy_i && !grant_q &&
               (wrsr_i || !hit_i);
  assign sr_wr_o = wrsr_i && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= req && ok;
      deny_q  <= req && !ok;
    end
  end

  assign grant_o = grant_q;
  assign deny_o  = deny_q;

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_q && deny_q));
  p_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> (grant_q || deny_q));
  p_grant_wel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> $past(wel_i && !busy_i));
  p_grant_wp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> $past(wp_i));
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_start_i,
  input  logic                sel_end_i,
  input  logic                bit_i,
  input  logic                wren_i,
  input  logic                wrdi_i,
  input  logic                wrsr_i,
  input  logic [STATUS_W-1:0] wrsr_data_i,
  input  logic                commit_i,
  input  logic [ADDR_W-1:0]   commit_lo_i,
  input  logic [ADDR_W-1:0]   commit_hi_i,
  input  logic                wp_i,
  input  logic                busy_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                grant_o,
  output logic                deny_o
);
  logic       wel, hit, sr_wr;
  logic [1:0] lvl;
  logic       unused_sr_bits;

  assign unused_sr_bits = ^{wrsr_data_i[7:4], wrsr_data_i[1:0]};

  wprot_wel u_wel (
    .clk_i, .rst_ni, .sel_start_i, .sel_end_i, .bit_i,
    .wren_i, .wrdi_i, .busy_i, .wel_o(wel)
  );

  wprot_bp #(.ADDR_W(ADDR_W)) u_bp (
    .clk_i, .rst_ni,
    .wr_en_i (sr_wr),
    .wr_lvl_i(wrsr_data_i[LVL_LSB+1:LVL_LSB]),
    .lo_i    (commit_lo_i),
    .hi_i    (commit_hi_i),
    .lvl_o   (lvl),
    .hit_o   (hit)
  );

  wprot_gate u_gate (
    .clk_i, .rst_ni, .sel_start_i, .sel_end_i, .commit_i, .wrsr_i,
    .wel_i(wel), .wp_i, .busy_i, .hit_i(hit),
    .sr_wr_o(sr_wr), .grant_o, .deny_o
  );

  assign status_o = busy_i ? '1 : {4'b0000, lvl, wel, 1'b0};

  p_busy_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (status_o == 8'hFF));
endmodule

// File: tb/wprot_status_unit_tb_top.sv
module wprot_status_unit_tb_top;
  localparam int unsigned AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_start = 0, sel_end = 0, bit_s = 0, wren = 0, wrdi = 0, wrsr = 0, commit = 0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] lo = '0, hi = '0;
  logic wp = 1'b1, busy = 1'b0;
  logic [7:0] status;
  logic grant, deny;

  always #2 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_start_i(sel_start), .sel_end_i(sel_end),
    .bit_i(bit_s), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_data_i(wrsr_data), .commit_i(commit), .commit_lo_i(lo),
    .commit_hi_i(hi), .wp_i(wp), .busy_i(busy), .status_o(status),
    .grant_o(grant), .deny_o(deny)
  );

  int checks = 0, fails = 0;
  bit m_wel = 0;
  logic [1:0] m_lvl = 2'b00;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic check(input bit cond, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && (grant || deny)) begin
      if (exp_q.size() == 0) check(0, "R10 unexpected verdict", {grant, deny}, 0);
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check((grant == e) && (deny == !e), t, {grant, deny}, {e, !e});
      end
    end
  end

  function automatic bit m_hit(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] s;
    case (m_lvl)
      2'b00: return 0;
      2'b01: s = 9'h180;
      2'b10: s = 9'h100;
      default: s = 9'h000;
    endcase
    return (a >= s) || (b >= s);
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk_status(input string req);
    logic [7:0] e;
    tick();
    e = busy ? 8'hFF : {4'b0, m_lvl, m_wel, 1'b0};
    check(status == e, req, status, e);
  endtask

  task automatic start_sel(); tick(); sel_start = 1; tick(); sel_start = 0; endtask

  task automatic do_wren(input bit extra);
    start_sel();
    for (int i = 0; i < 8; i++) begin bit_s = 1; tick(); bit_s = 0; end
    wren = 1; tick(); wren = 0;
    if (extra) begin bit_s = 1; tick(); bit_s = 0; end
    sel_end = 1; tick(); sel_end = 0;
    if (!busy && !extra) m_wel = 1;
  endtask

  task automatic do_wrdi();
    start_sel();
    wrdi = 1; tick(); wrdi = 0;
    sel_end = 1; tick(); sel_end = 0;
    if (!busy) m_wel = 0;
  endtask

  task automatic do_commit(input logic [AW-1:0] a, input logic [AW-1:0] b, input bit drop, input string req);
    bit ok;
    start_sel();
    if (drop) begin wp = 0; tick(); wp = 1; tick(); end
    ok = m_wel && wp && !drop && !busy && !m_hit(a, b);
    exp_q.push_back(ok); tag_q.push_back(req);
    lo = a; hi = b; commit = 1; sel_end = 1; tick(); commit = 0; sel_end = 0;
    tick(); tick();
  endtask

  task automatic do_wrsr(input logic [7:0] d, input string req);
    bit ok;
    start_sel();
    ok = m_wel && wp && !busy;
    exp_q.push_back(ok); tag_q.push_back(req);
    wrsr_data = d; wrsr = 1; sel_end = 1; tick(); wrsr = 0; sel_end = 0;
    if (ok) m_lvl = d[3:2];
    tick(); tick();
  endtask

  task automatic write_cycle();
    tick(); busy = 1;
    chk_status("R2 busy reads FF");
    tick(); tick(); busy = 0;
    tick(); tick();
    m_wel = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check(status == 8'h00 && !grant && !deny, "R1 reset state", {grant, deny, status}, 0);
    rst_n = 1;
    chk_status("R1 status after reset");

    do_wren(0);   chk_status("R3 enable sets latch");
    do_wrdi();    chk_status("R4 disable clears latch");
    do_wren(1);   chk_status("R3 extra bit discards enable");
    do_commit(9'h000, 9'h003, 0, "R9 latch clear denies");

    do_wren(0);
    do_wrsr(8'hF4, "R5 status write granted");
    chk_status("R5 level loaded from bits 3:2 only");
    write_cycle();
    chk_status("R4 latch clears after busy falls");

    do_wren(0);
    do_commit(9'h17C, 9'h17F, 0, "R6 below quarter granted");
    write_cycle();
    do_wren(0);
    do_commit(9'h180, 9'h183, 0, "R6 quarter region denied");
    do_commit(9'h1FE, 9'h1FD, 0, "R6 wrapped burst denied");
    wp = 0;
    do_commit(9'h000, 9'h003, 0, "R7 wp low denies");
    do_wrsr(8'h00, "R7 wp low denies status write");
    wp = 1;
    chk_status("R5 level unchanged after denied write");
    do_commit(9'h000, 9'h003, 1, "R8 wp dip in selection denies");
    do_commit(9'h000, 9'h003, 0, "R8 new selection clears cancel");
    write_cycle();

    do_wren(0);
    do_wrsr(8'h08, "R5 set half level");
    write_cycle();
    chk_status("R2 half level in status");
    do_wren(0);
    do_commit(9'h0FF, 9'h0FF, 0, "R6 0x0FF free at half");
    write_cycle();
    do_wren(0);
    do_commit(9'h100, 9'h100, 0, "R6 0x100 protected at half");
    do_wrsr(8'h0C, "R5 set full level");
    write_cycle();
    do_wren(0);
    do_commit(9'h000, 9'h000, 0, "R6 whole array protected");
    do_wrsr(8'h00, "R5 clear level");
    write_cycle();
    chk_status("R5 level cleared");

    // requests and commands while busy
    do_wren(0);
    tick(); busy = 1;
    do_commit(9'h000, 9'h000, 0, "R9 busy denies");
    do_wrdi();
    tick(); busy = 0; tick(); tick(); m_wel = 0;
    chk_status("R4 latch cleared at busy fall");
    tick(); busy = 1;
    do_wren(0);
    tick(); busy = 0; tick(); tick();
    chk_status("R4 enable ignored while busy");

    // back-to-back request after a grant
    do_wren(0);
    start_sel();
    exp_q.push_back(1); tag_q.push_back("R10 first of pair granted");
    exp_q.push_back(0); tag_q.push_back("R9 request after grant denied");
    lo = 9'h010; hi = 9'h010; commit = 1; tick(); tick(); commit = 0;
    sel_end = 1; tick(); sel_end = 0;
    write_cycle();
    chk_status("R4 latch clear after pair");

    tick(); tick();
    check(exp_q.size() == 0, "R10 all verdicts seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule